// File: doc/BRIEF.md
# Strobed Bidirectional Port

This block is one 8-bit port whose pins carry traffic in both directions, taking turns in time. The processor writes a byte into an output holding register, which raises an output-pending flag toward the peripheral. The peripheral pulls its acknowledge line low to take the byte. The port drives its pins only while acknowledge is low, and its pins float at all other times. In the other direction, the peripheral places a byte on the same pins and pulses its strobe low. The port copies that byte into a separate input holding register and raises an input-ready flag. The processor reads the byte, and that read clears the flag.

A single interrupt line combines two sources. The input source is armed at the end of a strobe, and the output source is armed at the end of an acknowledge. Each source has its own enable bit, and the enabled sources are ORed together. The processor side is a small synchronous register interface: chip select, active-low read and write strobes, a 2-bit address, and separate write and read data buses. The peripheral handshake inputs pass through a synchronizer. The pin driver is modelled as a data output plus an output-enable signal.

Top module: `strobed_bidir_port`

## Requirements
- R1: After a synchronous reset, `obf_n` is 1, `ibf`, `intr` and `pin_oe` are 0, and both interrupt enables are 0.
- R2: When `wr_n` rises at the end of a selected write to address 0, the written byte becomes the output byte and `obf_n` goes low on the next clock.
- R3: `pin_oe` is 1 and `pin_out` carries the output byte while the synchronized acknowledge is low (and the strobe is high). `pin_oe` returns to 0 after acknowledge returns high.
- R4: A falling edge of `ack_n` sets `obf_n` back to 1.
- R5: A falling edge of `stb_n` copies `pin_in` into the input byte and sets `ibf`.
- R6: A selected read of address 0 returns the input byte on `rdata`, and `ibf` clears when `rd_n` rises.
- R7: A rising edge of `stb_n` arms the input interrupt source, and a rising edge of `ack_n` arms the output source. `intr` is the OR of each source ANDed with its enable. A write to address 1 sets the input enable from data bit 0 and the output enable from data bit 1. With both enables at 0, `intr` stays 0.
- R8: A falling `rd_n` on a selected read of address 0 disarms the input source. A falling `wr_n` on a selected write to address 0 disarms the output source.
- R9: A selected read of address 1 returns a status byte with these bits: 7 = `obf_n`, 6 = output enable, 5 = `ibf`, 4 = input enable, 3 = `intr`. All other bits are 0.
- R10: `pin_oe` is never 1 in the cycle after the synchronized strobe is seen low, even if acknowledge is low.
- R11: If a flag is set and cleared in the same cycle, setting wins. An acknowledge fall together with a completing data write leaves `obf_n` low. A strobe fall together with a completing data read leaves `ibf` at 1 and latches the new byte.
- R12: With `cs_n` high, reads and writes have no effect on any flag or on the output byte, and `rdata` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 data, 1 control/status |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor (registered) |
| pin_in | input | 8 | Value sensed on the port pins |
| pin_out | output | 8 | Value driven onto the port pins |
| pin_oe | output | 1 | Pin driver enable |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output byte pending, active low |
| ibf | output | 1 | Input byte waiting |
| intr | output | 1 | Combined interrupt request |

## Verification
Each holding flag has one setting event from one side and one clearing event from the other side, and these two events can land on the same clock edge. The first collision is an acknowledge fall on the same edge as the rising edge of a data write. The second is a strobe fall on the same edge as the rising edge of a data read. Each is produced by starting the processor access early, changing the handshake input, and then releasing the processor strobe exactly two cycles later, so that the release meets the synchronizer latency. The result is judged at the ports. `obf_n` must stay low, `ibf` must stay high, and a follow-up read must return the byte captured during the collision.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_CTRL = 2'b01,
    SEL_RSV2 = 2'b10,
    SEL_RSV3 = 2'b11
  } sel_e;

  localparam int ST_OBF_N  = 7;
  localparam int ST_IE_OUT = 6;
  localparam int ST_IBF    = 5;
  localparam int ST_IE_IN  = 4;
  localparam int ST_INTR   = 3;

  localparam int CTRL_IE_IN  = 0;
  localparam int CTRL_IE_OUT = 1;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sbp_bus_if.sv
module sbp_bus_if
  import sbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] in_byte,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] out_byte,
  output logic          ie_in,
  output logic          ie_out,
  output logic          data_wr_rise,
  output logic          data_wr_fall,
  output logic          data_rd_rise,
  output logic          data_rd_fall
);
  logic          rd_prev, wr_prev;
  logic          wr_sel_data, wr_sel_ctrl, rd_sel_data;
  logic [DW-1:0] wr_hold;
  logic          hit_data, hit_ctrl, wr_rise_any, ctrl_wr_rise;

  assign hit_data = !cs_n && (addr == SEL_DATA);
  assign hit_ctrl = !cs_n && (addr == SEL_CTRL);

  assign wr_rise_any  = !wr_prev && wr_n;
  assign data_wr_rise = wr_rise_any && wr_sel_data;
  assign ctrl_wr_rise = wr_rise_any && wr_sel_ctrl;
  assign data_wr_fall = wr_prev && !wr_n && hit_data;
  assign data_rd_rise = !rd_prev && rd_n && rd_sel_data;
  assign data_rd_fall = rd_prev && !rd_n && hit_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev     <= 1'b1;
      wr_prev     <= 1'b1;
      wr_sel_data <= 1'b0;
      wr_sel_ctrl <= 1'b0;
      rd_sel_data <= 1'b0;
      wr_hold     <= '0;
      out_byte    <= '0;
      ie_in       <= 1'b0;
      ie_out      <= 1'b0;
      rdata       <= '0;
    end else begin
      rd_prev <= rd_n;
      wr_prev <= wr_n;

      if (!wr_n) begin
        wr_sel_data <= hit_data;
        wr_sel_ctrl <= hit_ctrl;
        wr_hold     <= wdata;
      end else begin
        wr_sel_data <= 1'b0;
        wr_sel_ctrl <= 1'b0;
      end

      if (!rd_n) rd_sel_data <= hit_data;
      else       rd_sel_data <= 1'b0;

      if (data_wr_rise) out_byte <= wr_hold;
      if (ctrl_wr_rise) begin
        ie_in  <= wr_hold[CTRL_IE_IN];
        ie_out <= wr_hold[CTRL_IE_OUT];
      end

      if (!rd_n && hit_data)      rdata <= in_byte;
      else if (!rd_n && hit_ctrl) rdata <= status;
      else                        rdata <= '0;
    end
  end
endmodule

// File: rtl/sbp_handshake.sv
module sbp_handshake #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_low_s,
  input  logic          ack_low_s,
  input  logic [DW-1:0] pin_in,
  input  logic [DW-1:0] out_byte,
  input  logic          data_wr_rise,
  input  logic          data_wr_fall,
  input  logic          data_rd_rise,
  input  logic          data_rd_fall,
  input  logic          ie_in,
  input  logic          ie_out,
  output logic          obf_n,
  output logic          ibf,
  output logic          intr,
  output logic [DW-1:0] in_byte,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  output logic          stb_fall_ev,
  output logic          ack_fall_ev
);
  logic stb_prev, ack_prev;
  logic stb_rise_ev, ack_rise_ev;
  logic irq_in, irq_out, irq_in_d, irq_out_d;

  assign stb_fall_ev = stb_low_s && !stb_prev;
  assign stb_rise_ev = !stb_low_s && stb_prev;
  assign ack_fall_ev = ack_low_s && !ack_prev;
  assign ack_rise_ev = !ack_low_s && ack_prev;

  always_comb begin
    irq_in_d = irq_in;
    if (stb_rise_ev)       irq_in_d = 1'b1;
    else if (data_rd_fall) irq_in_d = 1'b0;
    irq_out_d = irq_out;
    if (ack_rise_ev)       irq_out_d = 1'b1;
    else if (data_wr_fall) irq_out_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev <= 1'b0;
      ack_prev <= 1'b0;
      obf_n    <= 1'b1;
      ibf      <= 1'b0;
      irq_in   <= 1'b0;
      irq_out  <= 1'b0;
      intr     <= 1'b0;
      in_byte  <= '0;
      pin_out  <= '0;
      pin_oe   <= 1'b0;
    end else begin
      stb_prev <= stb_low_s;
      ack_prev <= ack_low_s;

      if (data_wr_rise)     obf_n <= 1'b0;
      else if (ack_fall_ev) obf_n <= 1'b1;

      if (stb_fall_ev) begin
        ibf     <= 1'b1;
        in_byte <= pin_in;
      end else if (data_rd_rise) begin
        ibf <= 1'b0;
      end

      irq_in  <= irq_in_d;
      irq_out <= irq_out_d;
      intr    <= (ie_in && irq_in_d) || (ie_out && irq_out_d);

      pin_out <= out_byte;
      pin_oe  <= ack_low_s && !stb_low_s;
    end
  end
endmodule

// File: rtl/strobed_bidir_port.sv
module strobed_bidir_port
  import sbp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  input  logic          stb_n,
  input  logic          ack_n,
  output logic          obf_n,
  output logic          ibf,
  output logic          intr
);
  logic [1:0]    hs_sync;
  logic          stb_low_s, ack_low_s;
  logic [DW-1:0] in_byte, out_byte, status;
  logic          ie_in, ie_out;
  logic          data_wr_rise, data_wr_fall, data_rd_rise, data_rd_fall;
  logic          stb_fall_ev, ack_fall_ev;

  sbp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ack_n, stb_n}),
    .q   (hs_sync)
  );

  assign stb_low_s = !hs_sync[0];
  assign ack_low_s = !hs_sync[1];

  always_comb begin
    status            = '0;
    status[ST_OBF_N]  = obf_n;
    status[ST_IE_OUT] = ie_out;
    status[ST_IBF]    = ibf;
    status[ST_IE_IN]  = ie_in;
    status[ST_INTR]   = intr;
  end

  sbp_bus_if #(.DW(DW)) u_bus (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .addr         (addr),
    .wdata        (wdata),
    .in_byte      (in_byte),
    .status       (status),
    .rdata        (rdata),
    .out_byte     (out_byte),
    .ie_in        (ie_in),
    .ie_out       (ie_out),
    .data_wr_rise (data_wr_rise),
    .data_wr_fall (data_wr_fall),
    .data_rd_rise (data_rd_rise),
    .data_rd_fall (data_rd_fall)
  );

  sbp_handshake #(.DW(DW)) u_hs (
    .clk          (clk),
    .rst          (rst),
    .stb_low_s    (stb_low_s),
    .ack_low_s    (ack_low_s),
    .pin_in       (pin_in),
    .out_byte     (out_byte),
    .data_wr_rise (data_wr_rise),
    .data_wr_fall (data_wr_fall),
    .data_rd_rise (data_rd_rise),
    .data_rd_fall (data_rd_fall),
    .ie_in        (ie_in),
    .ie_out       (ie_out),
    .obf_n        (obf_n),
    .ibf          (ibf),
    .intr         (intr),
    .in_byte      (in_byte),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .stb_fall_ev  (stb_fall_ev),
    .ack_fall_ev  (ack_fall_ev)
  );
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker (
  input logic clk,
  input logic rst,
  input logic pin_oe,
  input logic obf_n,
  input logic ibf,
  input logic intr,
  input logic stb_low_s,
  input logic ack_low_s,
  input logic wr_rise_ev,
  input logic ack_fall_ev,
  input logic stb_fall_ev,
  input logic ie_in,
  input logic ie_out
);
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (obf_n && !ibf && !intr && !pin_oe));

  a_r2_write_sets_obf: assert property (@(posedge clk) disable iff (rst)
    wr_rise_ev |=> !obf_n);

  a_r4_ack_clears_obf: assert property (@(posedge clk) disable iff (rst)
    (ack_fall_ev && !wr_rise_ev) |=> obf_n);

  a_r5_strobe_sets_ibf: assert property (@(posedge clk) disable iff (rst)
    stb_fall_ev |=> ibf);

  a_r3_drive_on_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_low_s && !stb_low_s) |=> pin_oe);

  a_r3_float_off_ack: assert property (@(posedge clk) disable iff (rst)
    !ack_low_s |=> !pin_oe);

  a_r10_no_drive_in_strobe: assert property (@(posedge clk) disable iff (rst)
    stb_low_s |=> !pin_oe);

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ie_in && !ie_out) |=> !intr);

  a_r11_write_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (wr_rise_ev && ack_fall_ev) |=> !obf_n);
endmodule

bind strobed_bidir_port sbp_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .pin_oe      (pin_oe),
  .obf_n       (obf_n),
  .ibf         (ibf),
  .intr        (intr),
  .stb_low_s   (stb_low_s),
  .ack_low_s   (ack_low_s),
  .wr_rise_ev  (data_wr_rise),
  .ack_fall_ev (ack_fall_ev),
  .stb_fall_ev (stb_fall_ev),
  .ie_in       (ie_in),
  .ie_out      (ie_out)
);

// File: tb/strobed_bidir_port_tb_top.sv
module strobed_bidir_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00, pin_in = 8'h00;
  logic       stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] rdata, pin_out;
  logic       pin_oe, obf_n, ibf, intr;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rd_val;

  always #2 clk = ~clk;

  strobed_bidir_port dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .stb_n(stb_n), .ack_n(ack_n),
    .obf_n(obf_n), .ibf(ibf), .intr(intr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk); d = rdata; rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 obf_n", obf_n, 1); chk("R1 ibf", ibf, 0);
    chk("R1 intr", intr, 0);   chk("R1 pin_oe", pin_oe, 0);
    bus_read(2'b01, rd_val);
    chk("R1/R9 status after reset", rd_val, 8'h80);
  endtask

  task automatic t_output();
    bus_write(2'b00, 8'hA5);
    chk("R2 obf_n low after write", obf_n, 0);
    chk("R3 float with ack high", pin_oe, 0);
    ack_n = 1'b0; settle();
    chk("R3 drive on ack", pin_oe, 1);
    chk("R3 pin_out byte", pin_out, 8'hA5);
    chk("R4 obf_n after ack fall", obf_n, 1);
    ack_n = 1'b1; settle();
    chk("R3 float after ack", pin_oe, 0);
  endtask

  task automatic t_input();
    pin_in = 8'h3C; stb_n = 1'b0; settle();
    chk("R5 ibf set", ibf, 1);
    stb_n = 1'b1; settle(); pin_in = 8'hFF;
    bus_read(2'b00, rd_val);
    chk("R6 read input byte", rd_val, 8'h3C);
    chk("R6 ibf cleared", ibf, 0);
    ack_n = 1'b0; stb_n = 1'b0; settle();
    chk("R10 no drive while strobe low", pin_oe, 0);
    stb_n = 1'b1; settle();
    chk("R3 drive resumes", pin_oe, 1);
    ack_n = 1'b1; settle();
    bus_read(2'b00, rd_val);
    chk("R6 ibf cleared again", ibf, 0);
  endtask

  task automatic t_intr();
    bus_write(2'b01, 8'h01);
    stb_n = 1'b0; settle();
    chk("R7 no intr before strobe end", intr, 0);
    stb_n = 1'b1; settle();
    chk("R7 intr on strobe end", intr, 1);
    bus_read(2'b01, rd_val);
    chk("R9 status in-side", rd_val, 8'hB8);
    @(negedge clk); cs_n = 1'b0; addr = 2'b00; rd_n = 1'b0;
    @(negedge clk); chk("R8 read fall clears intr", intr, 0); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    bus_write(2'b01, 8'h02);
    @(negedge clk); cs_n = 1'b0; addr = 2'b00; wdata = 8'h5A; wr_n = 1'b0;
    @(negedge clk); chk("R8 write fall clears intr", intr, 0); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    ack_n = 1'b0; settle(); ack_n = 1'b1; settle();
    chk("R7 intr on ack end", intr, 1);
    bus_read(2'b01, rd_val);
    chk("R9 status out-side", rd_val, 8'hC8);
    bus_write(2'b01, 8'h00); @(negedge clk);
    chk("R7 masked intr", intr, 0);
  endtask

  task automatic t_cs();
    @(negedge clk); cs_n = 1'b1; addr = 2'b00; wdata = 8'h77; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    chk("R12 obf_n untouched", obf_n, 1);
    rd_n = 1'b0; @(negedge clk);
    chk("R12 rdata idle", rdata, 8'h00); rd_n = 1'b1;
    ack_n = 1'b0; settle();
    chk("R12 output byte kept", pin_out, 8'h5A);
    ack_n = 1'b1; settle();
  endtask

  task automatic t_collide();
    @(negedge clk); cs_n = 1'b0; addr = 2'b00; wdata = 8'hC3; wr_n = 1'b0;
    @(negedge clk); ack_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk("R11 write wins over ack", obf_n, 0);
    ack_n = 1'b1; settle();
    pin_in = 8'h11; stb_n = 1'b0; settle(); stb_n = 1'b1; settle();
    @(negedge clk); cs_n = 1'b0; addr = 2'b00; rd_n = 1'b0;
    @(negedge clk); stb_n = 1'b0; pin_in = 8'h22;
    repeat (2) @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk("R11 strobe wins over read", ibf, 1);
    stb_n = 1'b1; settle();
    bus_read(2'b00, rd_val);
    chk("R11 new byte latched", rd_val, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_intr();
    t_cs();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule